// File: doc/BRIEF.md
# Four-Strike Watchdog Timer

This block is a bus-programmed watchdog. Software sets a period in watchdog ticks, starts the count and must restart it before it has run down four times in a row. Each run-down of the period is an expiration. The first three expirations only reload the count, advance an expiration index and optionally pulse an interrupt. The fourth one raises a system-reset request, which stays raised until the block's own reset.

Watchdog ticks come from one internal periodic timer. That timer counts a 1 MHz clock-enable input and is programmed through its own control word. Stopping the watchdog is guarded by a key: a disable command only acts when a key write came just before it, and each disable command uses up the key.

All registers sit on a simple write port with 32-bit data. Read data is combinational from the address.

Top module: `wdt_fourstrike`

## Requirements
- R1: The configuration register at offset 0x0 holds a tick-source id in bits [3:0], the period in bits [11:4], the interrupt enable in bit 12 and the reset enable in bit 15. Other bits read as 0. Each written field reads back unchanged, periods 1 and 255 included.
- R2: The status register at offset 0x4 shows the live down-count in bits [11:4] and the expiration index (0 to 3) in bits [13:12]. All other bits read 0. The command and key offsets read 0.
- R3: Writing bit 0 to the command register at offset 0x8 starts the watchdog, or restarts it as a keepalive. The count loads the period and the index clears to 0.
- R4: While running, the count drops by one per timer tick. A tick that finds the count at 1 or 0 is an expiration: the count reloads the period and the index increments. A period of 0 behaves like 1. A command write in the same cycle as a tick takes precedence, and that tick is dropped.
- R5: On the fourth expiration, with the reset enable set, the reset request rises and stays high until rst_n. Start and disable commands do not clear it. Counting carries on with the index back at 0.
- R6: With the reset enable clear, the fourth expiration raises no reset request, and the index wraps to 0.
- R7: With the interrupt enable set, wdt_irq is high for exactly one cycle on the first, second and third expirations. It stays low on the fourth expiration, and always when the interrupt enable is clear.
- R8: Command bit 1 stops the watchdog only if the last write to the key register at offset 0xC was exactly 0x0000C45A, with no disable in between. Otherwise the disable is ignored and counting goes on. While stopped, ticks leave the count unchanged.
- R9: Any disable command uses up the key. Writing any other value to the key register clears a pending key.
- R10: The timer control word at offset 0x10 has enable in bit 31, periodic reload in bit 30 and a reload value N in bits [29:0]. It reads back as written. An enabled timer gives one watchdog tick every N us_tick pulses, with N = 0 acting as 1. A one-shot timer (bit 30 clear) clears its own enable after its tick.
- R11: Writing the timer control word with bit 31 clear stops ticks, so the watchdog count and index freeze.
- R12: After reset every register reads 0, wdt_irq and sys_rst_req are low, and the watchdog is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | 1 MHz clock-enable pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wdt_irq | output | 1 | One-cycle interrupt on expirations one to three |
| sys_rst_req | output | 1 | Sticky system-reset request |

## Verification
The assertions assume at most one register write per cycle. They also assume the interrupt enable is judged against the value held when an expiration is counted, so a configuration write landing on the same edge does not count as a violation. The bench drives every bus write and every us_tick pulse in separate cycles. It therefore never relies on the command-over-tick precedence, and every expected count and index follows from tick and write order alone. Interrupt pulses are sampled in the cycle right after each tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W       = 32;
    localparam int OFS_CFG      = 'h00;
    localparam int OFS_STS      = 'h04;
    localparam int OFS_CMD      = 'h08;
    localparam int OFS_KEY      = 'h0C;
    localparam int OFS_TMR      = 'h10;
    localparam logic [31:0] KEY_VALUE = 32'h0000_C45A;
    localparam int ID_W         = 4;
    localparam int PERIOD_LSB   = 4;
    localparam int IRQ_EN_BIT   = 12;
    localparam int RST_EN_BIT   = 15;
    localparam int IDX_LSB      = 12;
    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_STOP_BIT = 1;
    localparam int TMR_EN_BIT   = 31;
    localparam int TMR_PER_BIT  = 30;
endpackage

// File: rtl/wdt_tick_timer.sv
module wdt_tick_timer
    import wdt_pkg::*;
#(
    parameter int RELOAD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick_i,
    input  logic              ctrl_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              fire_o
);
    localparam int PAD_W = DATA_W - 2 - RELOAD_W;

    typedef struct packed {
        logic                en;
        logic                periodic;
        logic [RELOAD_W-1:0] reload;
        logic [RELOAD_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic at_end;

    assign at_end = (t_q.cnt <= RELOAD_W'(1));
    assign fire_o = !ctrl_we_i && us_tick_i && t_q.en && at_end;
    assign ctrl_o = {t_q.en, t_q.periodic, {PAD_W{1'b0}}, t_q.reload};

    always_comb begin
        t_d = t_q;
        if (ctrl_we_i) begin
            t_d.en       = wdata_i[TMR_EN_BIT];
            t_d.periodic = wdata_i[TMR_PER_BIT];
            t_d.reload   = wdata_i[RELOAD_W-1:0];
            t_d.cnt      = wdata_i[RELOAD_W-1:0];
        end else if (us_tick_i && t_q.en) begin
            if (at_end) begin
                t_d.cnt = t_q.reload;
                if (!t_q.periodic) t_d.en = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - RELOAD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // a stopped timer stays stopped and frozen until rewritten
    assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we_i && !t_q.en) |=> (!t_q.en && $stable(t_q.cnt)));

    // a one-shot timer drops its enable after firing
    assert_oneshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !t_q.periodic) |=> !t_q.en);
endmodule

// File: rtl/wdt_strike_core.sv
module wdt_strike_core
    import wdt_pkg::*;
#(
    parameter int PERIOD_W = 8,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cfg_we_i,
    input  logic              cmd_we_i,
    input  logic              key_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_o,
    output logic [DATA_W-1:0] sts_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        logic [ID_W-1:0]     src_id;
        logic [PERIOD_W-1:0] period;
        logic                irq_en;
        logic                rst_en;
        logic                running;
        logic                armed;
        logic [PERIOD_W-1:0] cnt;
        logic [IDX_W-1:0]    idx;
        logic                irq;
        logic                rst;
    } core_t;

    core_t s_d, s_q;
    logic go_req, stop_req, stop_ok;

    assign go_req   = cmd_we_i && wdata_i[CMD_GO_BIT];
    assign stop_req = cmd_we_i && wdata_i[CMD_STOP_BIT];
    assign stop_ok  = stop_req && s_q.armed;

    always_comb begin
        cfg_o = '0;
        cfg_o[ID_W-1:0]                 = s_q.src_id;
        cfg_o[PERIOD_LSB +: PERIOD_W]   = s_q.period;
        cfg_o[IRQ_EN_BIT]               = s_q.irq_en;
        cfg_o[RST_EN_BIT]               = s_q.rst_en;
        sts_o = '0;
        sts_o[PERIOD_LSB +: PERIOD_W]   = s_q.cnt;
        sts_o[IDX_LSB +: IDX_W]         = s_q.idx;
    end

    assign irq_o     = s_q.irq;
    assign rst_req_o = s_q.rst;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (cfg_we_i) begin
            s_d.src_id = wdata_i[ID_W-1:0];
            s_d.period = wdata_i[PERIOD_LSB +: PERIOD_W];
            s_d.irq_en = wdata_i[IRQ_EN_BIT];
            s_d.rst_en = wdata_i[RST_EN_BIT];
        end
        if (key_we_i) s_d.armed = (wdata_i == KEY_VALUE);
        if (cmd_we_i) begin
            if (stop_req) s_d.armed = 1'b0;
            if (stop_ok) begin
                s_d.running = 1'b0;
            end else if (go_req) begin
                s_d.running = 1'b1;
                s_d.cnt     = s_q.period;
                s_d.idx     = '0;
            end
        end else if (tick_i && s_q.running) begin
            if (s_q.cnt <= PERIOD_W'(1)) begin
                s_d.cnt = s_q.period;
                if (s_q.idx == LAST_IDX) begin
                    s_d.idx = '0;
                    if (s_q.rst_en) s_d.rst = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                    s_d.irq = s_q.irq_en;
                end
            end else begin
                s_d.cnt = s_q.cnt - PERIOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_rst_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst |=> s_q.rst);

    assert_irq_context_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> (s_q.idx != '0 && $past(s_q.irq_en)));

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cmd_we_i) |=> ($stable(s_q.cnt) && $stable(s_q.idx)));

    assert_locked_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !go_req && !s_q.armed) |=> (s_q.running == $past(s_q.running)));
endmodule

// File: rtl/wdt_fourstrike.sv
module wdt_fourstrike
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int PERIOD_W = 8,
    parameter int RELOAD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_irq,
    output logic              sys_rst_req
);
    logic cfg_we, cmd_we, key_we, tmr_we, wd_tick;
    logic [DATA_W-1:0] cfg_rd, sts_rd, tmr_rd;

    assign cfg_we = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
    assign cmd_we = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign key_we = bus_we && (bus_addr == ADDR_W'(OFS_KEY));
    assign tmr_we = bus_we && (bus_addr == ADDR_W'(OFS_TMR));

    wdt_tick_timer #(.RELOAD_W(RELOAD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick_i (us_tick),
        .ctrl_we_i (tmr_we),
        .wdata_i   (bus_wdata),
        .ctrl_o    (tmr_rd),
        .fire_o    (wd_tick)
    );

    wdt_strike_core #(.PERIOD_W(PERIOD_W), .IDX_W(2)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (wd_tick),
        .cfg_we_i  (cfg_we),
        .cmd_we_i  (cmd_we),
        .key_we_i  (key_we),
        .wdata_i   (bus_wdata),
        .cfg_o     (cfg_rd),
        .sts_o     (sts_rd),
        .irq_o     (wdt_irq),
        .rst_req_o (sys_rst_req)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CFG): bus_rdata = cfg_rd;
            ADDR_W'(OFS_STS): bus_rdata = sts_rd;
            ADDR_W'(OFS_TMR): bus_rdata = tmr_rd;
            default:          bus_rdata = '0;
        endcase
    end

    // the interrupt and the reset request never share a cycle's cause
    assert_irq_not_fourth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sys_rst_req)) |-> !wdt_irq);
endmodule

// File: tb/wdt_fourstrike_tb.sv
module wdt_fourstrike_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq, sys_rst_req;
    int checks = 0;
    int errors = 0;
    logic irq_seen;
    logic done = 1'b0;

    always #2 clk = ~clk;

    wdt_fourstrike u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
        irq_seen = wdt_irq;
    endtask

    function automatic logic [31:0] sts(input int cnt, input int idx);
        return (32'(cnt) << 4) | (32'(idx) << 12);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(5'h00, d); check("R12 cfg", d, 0);
        rd(5'h04, d); check("R12 sts", d, 0);
        rd(5'h10, d); check("R12 tmr", d, 0);
        check("R12 irq", wdt_irq, 0);
        check("R12 rst", sys_rst_req, 0);
        wr(5'h10, 32'hC000_0001);
        tick();
        rd(5'h04, d); check("R12 stopped after reset", d, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        do_reset();
        wr(5'h00, 32'hFFFF_9035);
        rd(5'h00, d); check("R1 fields", d, 32'h0000_9035);
        wr(5'h00, 32'h0000_0FF0);
        rd(5'h00, d); check("R1 period 255", d, 32'h0000_0FF0);
        wr(5'h00, 32'h0000_0010);
        rd(5'h00, d); check("R1 period 1", d, 32'h0000_0010);
        rd(5'h08, d); check("R2 cmd reads 0", d, 0);
        rd(5'h0C, d); check("R2 key reads 0", d, 0);
    endtask

    task automatic t_count_and_fourth();
        logic [31:0] d;
        int irqs;
        do_reset();
        wr(5'h10, 32'hC000_0001);
        rd(5'h10, d); check("R10 readback", d, 32'hC000_0001);
        wr(5'h00, 32'h0000_9035);
        wr(5'h08, 32'h1);
        rd(5'h04, d); check("R3 start loads period", d, sts(3, 0));
        tick(); rd(5'h04, d); check("R4 dec 1", d, sts(2, 0));
        check("R7 no irq mid-period", irq_seen, 0);
        tick(); rd(5'h04, d); check("R4 dec 2", d, sts(1, 0));
        tick(); rd(5'h04, d); check("R4 first expiry", d, sts(3, 1));
        check("R7 irq first expiry", irq_seen, 1);
        @(negedge clk); check("R7 irq one cycle", wdt_irq, 0);
        tick(); wr(5'h08, 32'h1);
        rd(5'h04, d); check("R3 keepalive", d, sts(3, 0));
        irqs = 0;
        for (int i = 0; i < 11; i++) begin
            tick();
            if (irq_seen) irqs++;
        end
        check("R7 irq count first three", irqs, 3);
        rd(5'h04, d); check("R5 before fourth", d, sts(1, 3));
        check("R5 no reset yet", sys_rst_req, 0);
        tick();
        check("R5 reset on fourth", sys_rst_req, 1);
        check("R7 no irq on fourth", irq_seen, 0);
        rd(5'h04, d); check("R5 index wraps", d, sts(3, 0));
        wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'h2); wr(5'h08, 32'h1);
        check("R5 sticky", sys_rst_req, 1);
        do_reset();
        check("R5 cleared by rst_n", sys_rst_req, 0);
    endtask

    task automatic t_no_reset();
        logic [31:0] d;
        int irqs;
        do_reset();
        wr(5'h10, 32'hC000_0001);
        wr(5'h00, 32'h0000_0010);
        wr(5'h08, 32'h1);
        irqs = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (irq_seen) irqs++;
        end
        check("R6 no reset request", sys_rst_req, 0);
        check("R7 no irq when disabled", irqs, 0);
        rd(5'h04, d); check("R6 index wraps", d, sts(1, 0));
    endtask

    task automatic t_unlock();
        logic [31:0] d;
        do_reset();
        wr(5'h10, 32'hC000_0001);
        wr(5'h00, 32'h0000_0050);
        wr(5'h08, 32'h1);
        wr(5'h08, 32'h2);
        tick(); rd(5'h04, d); check("R8 disable without key ignored", d, sts(4, 0));
        wr(5'h0C, 32'h0000_1234); wr(5'h08, 32'h2);
        tick(); rd(5'h04, d); check("R9 wrong key ignored", d, sts(3, 0));
        wr(5'h0C, 32'h0000_C45A); wr(5'h0C, 32'h0000_0000); wr(5'h08, 32'h2);
        tick(); rd(5'h04, d); check("R9 key cleared by other value", d, sts(2, 0));
        wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'h2);
        tick(); rd(5'h04, d); check("R8 disabled freezes", d, sts(2, 0));
        wr(5'h08, 32'h1); wr(5'h08, 32'h2);
        tick(); rd(5'h04, d); check("R9 key used up", d, sts(4, 0));
    endtask

    task automatic t_timer();
        logic [31:0] d;
        do_reset();
        wr(5'h00, 32'h0000_0050);
        wr(5'h10, 32'hC000_0002);
        wr(5'h08, 32'h1);
        tick(); rd(5'h04, d); check("R10 reload 2 first pulse", d, sts(5, 0));
        tick(); rd(5'h04, d); check("R10 reload 2 second pulse", d, sts(4, 0));
        wr(5'h10, 32'h8000_0001);
        tick(); rd(5'h04, d); check("R10 one-shot fires", d, sts(3, 0));
        rd(5'h10, d); check("R10 one-shot clears enable", d, 32'h0000_0001);
        tick(); rd(5'h04, d); check("R10 one-shot no repeat", d, sts(3, 0));
        wr(5'h10, 32'h4000_0001);
        tick(); tick(); rd(5'h04, d); check("R11 timer stopped freezes", d, sts(3, 0));
        wr(5'h10, 32'hC000_0000);
        tick(); rd(5'h04, d); check("R10 reload 0 acts as 1", d, sts(2, 0));
    endtask

    initial begin
        t_reset();
        t_config();
        t_count_and_fourth();
        t_no_reset();
        t_unlock();
        t_timer();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule